// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a two-channel serial audio stream into parallel 24-bit left and right samples. Three wires arrive from outside: the bit clock, the frame clock and the serial data line. All three are sampled in one fast system clock domain, so the system clock must be several times faster than the bit clock. A data bit is taken on each rising edge of the sampled bit clock. A level change of the frame clock marks the border between two half-frames.

A 3-bit format code picks one of five framings. In 24-bit MSB-justified mode the word starts at the frame-clock edge. In I2S mode it starts one bit clock after that edge. In the three LSB-justified modes (16, 20 and 24 bits) the word ends at the next edge. Each word is sign-extended to 24 bits. Once the right channel of a frame is complete, both words are updated together and a one-cycle strobe marks the new pair.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is high, and after it is released until the first strobe, `left_out` and `right_out` read zero and `sample_valid` is low.
- R2: With format code 3'b010, the left word is sent while the frame clock is high. The word is the first 24 bits after the frame-clock edge, MSB first, two's complement, taken on rising bit-clock edges. Bits after the 24th in a half-frame are ignored. It works at 24 and at 32 bit clocks per half-frame.
- R3: With code 3'b011 (I2S), the left word is sent while the frame clock is low. Its MSB arrives on the second bit clock after the edge. This holds at 24 bit clocks per half-frame, where the LSB falls on the first bit of the next half-frame.
- R4: With code 3'b100, the word is the last 24 bits before the frame-clock edge. Earlier bits are ignored. The left channel is sent while the frame clock is high.
- R5: With code 3'b001, the word is the last 20 bits before the edge, sign-extended from bit 19. It works at 20 bits per half-frame.
- R6: With code 3'b000, the word is the last 16 bits before the edge, sign-extended from bit 15. It works at 16 bits per half-frame.
- R7: `sample_valid` is high for exactly one system clock per frame, after the right word completes. Both outputs change only in that cycle and hold their values otherwise.
- R8: After reset, a half-frame already in progress is discarded. No strobe is given until a full left word and then a full right word have been received.
- R9: The unassigned codes 3'b101 to 3'b111 decode exactly like 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| lrck_in | input | 1 | Frame clock selecting the channel |
| sdata_in | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Framing code (see R2 to R6, R9) |
| left_out | output | 24 | Sign-extended left sample |
| right_out | output | 24 | Sign-extended right sample |
| sample_valid | output | 1 | One-cycle strobe when a new pair is present |

## Verification
Every format is driven at its minimum bit-clock rate and at 32 bits per half-frame. Padding bits are set to ones, so a word taken from the wrong slot or shifted by one bit shows up as a wrong value. The test words use set and cleared top bits, which separates correct sign extension from zero fill for the 16-bit and 20-bit modes. The I2S runs at 24 bits per half-frame tell a true one-bit delay apart from a word cut at the frame-clock edge. A stream that starts in the middle of a left half-frame shows whether a partial word is wrongly paired into a frame.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  typedef enum logic [2:0] {
    FMT_LSB16 = 3'b000,
    FMT_LSB20 = 3'b001,
    FMT_MSB24 = 3'b010,
    FMT_I2S24 = 3'b011,
    FMT_LSB24 = 3'b100
  } asrx_fmt_e;

  localparam int SHORT_W = 16;
  localparam int MID_W   = 20;

  // Unassigned codes fall back to the MSB-justified framing.
  function automatic asrx_fmt_e decode_fmt(input logic [2:0] code);
    if (code > 3'b100) return FMT_MSB24;
    return asrx_fmt_e'(code);
  endfunction

endpackage

// File: rtl/asrx_edge_sync.sv
module asrx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic lrck_in,
  input  logic sdata_in,
  output logic bit_rise,
  output logic lr_bit,
  output logic sd_bit
);

  localparam int LAST = SYNC_STAGES - 1;

  // lane 2 = bit clock, lane 1 = frame clock, lane 0 = data
  logic [2:0] stage_q [SYNC_STAGES];
  logic       bclk_prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= {bclk_in, lrck_in, sdata_in};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bclk_prev_q <= 1'b0;
    else     bclk_prev_q <= stage_q[LAST][2];
  end

  assign bit_rise = stage_q[LAST][2] & ~bclk_prev_q;
  assign lr_bit   = stage_q[LAST][1];
  assign sd_bit   = stage_q[LAST][0];

  assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
    bit_rise |=> !bit_rise);

endmodule

// File: rtl/asrx_shift_engine.sv
module asrx_shift_engine
  import asrx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_rise,
  input  logic              lr_bit,
  input  logic              sd_bit,
  input  asrx_fmt_e         fmt,
  output logic              word_done,
  output logic [WORD_W-1:0] word_data,
  output logic              word_left,
  output asrx_fmt_e         word_fmt
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [1:0]        lr_hist_q;
  logic [1:0]        hist_cnt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sreg_q;
  logic              in_frame_q;

  logic             is_i2s, is_lsb, lr_cur, lr_old, hist_ok, edge_seen, take, left_lvl;
  logic [CNT_W-1:0] idx;

  always_comb begin
    is_i2s    = (fmt == FMT_I2S24);
    is_lsb    = (fmt == FMT_LSB16) || (fmt == FMT_LSB20) || (fmt == FMT_LSB24);
    // I2S is MSB-justified framing on a frame clock delayed by one bit.
    lr_cur    = is_i2s ? lr_hist_q[0] : lr_bit;
    lr_old    = is_i2s ? lr_hist_q[1] : lr_hist_q[0];
    hist_ok   = is_i2s ? (hist_cnt_q == 2'd2) : (hist_cnt_q != 2'd0);
    edge_seen = hist_ok && (lr_cur != lr_old);
    idx       = edge_seen ? '0 : cnt_q;
    take      = is_lsb || (idx < CNT_MAX);
    left_lvl  = !is_i2s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_hist_q  <= '0;
      hist_cnt_q <= '0;
      cnt_q      <= '0;
      sreg_q     <= '0;
      in_frame_q <= 1'b0;
      word_done  <= 1'b0;
      word_data  <= '0;
      word_left  <= 1'b0;
      word_fmt   <= FMT_MSB24;
    end else begin
      word_done <= 1'b0;
      if (bit_rise) begin
        lr_hist_q <= {lr_hist_q[0], lr_bit};
        if (hist_cnt_q != 2'd2) hist_cnt_q <= hist_cnt_q + 2'd1;
        cnt_q <= (idx == CNT_MAX) ? idx : idx + 1'b1;
        if (take) sreg_q <= {sreg_q[WORD_W-2:0], sd_bit};
        if (edge_seen) begin
          in_frame_q <= 1'b1;
          if (in_frame_q) begin
            word_done <= 1'b1;
            word_data <= sreg_q;
            word_left <= (lr_old == left_lvl);
            word_fmt  <= fmt;
          end
        end
      end
    end
  end

  assert_done_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(bit_rise));

  assert_no_early_word_R8: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(in_frame_q));

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/asrx_word_align.sv
module asrx_word_align
  import asrx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_left,
  input  asrx_fmt_e         word_fmt,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              sample_valid
);

  logic [WORD_W-1:0] ext;
  logic [WORD_W-1:0] left_hold_q;
  logic              left_pend_q;

  always_comb begin
    case (word_fmt)
      FMT_LSB16: ext = {{(WORD_W-SHORT_W){word_data[SHORT_W-1]}}, word_data[SHORT_W-1:0]};
      FMT_LSB20: ext = {{(WORD_W-MID_W){word_data[MID_W-1]}}, word_data[MID_W-1:0]};
      default:   ext = word_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold_q  <= '0;
      left_pend_q  <= 1'b0;
      left_out     <= '0;
      right_out    <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (word_done) begin
        if (word_left) begin
          left_hold_q <= ext;
          left_pend_q <= 1'b1;
        end else if (left_pend_q) begin
          left_out     <= left_hold_q;
          right_out    <= ext;
          sample_valid <= 1'b1;
          left_pend_q  <= 1'b0;
        end
      end
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  assert_strobe_after_right_R7: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(word_done && !word_left));

  assert_outputs_held_R7: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> ($stable(left_out) && $stable(right_out)));

  assert_sext_short_R6: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && $past(word_fmt == FMT_LSB16))
      |-> (right_out[WORD_W-1:SHORT_W] == {(WORD_W-SHORT_W){right_out[SHORT_W-1]}}));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              lrck_in,
  input  logic              sdata_in,
  input  logic [2:0]        fmt_sel,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              sample_valid
);

  logic              bit_rise, lr_bit, sd_bit;
  logic              word_done, word_left;
  logic [WORD_W-1:0] word_data;
  asrx_fmt_e         fmt, word_fmt;

  assign fmt = decode_fmt(fmt_sel);

  asrx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .bclk_in  (bclk_in),
    .lrck_in  (lrck_in),
    .sdata_in (sdata_in),
    .bit_rise (bit_rise),
    .lr_bit   (lr_bit),
    .sd_bit   (sd_bit)
  );

  asrx_shift_engine #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_rise  (bit_rise),
    .lr_bit    (lr_bit),
    .sd_bit    (sd_bit),
    .fmt       (fmt),
    .word_done (word_done),
    .word_data (word_data),
    .word_left (word_left),
    .word_fmt  (word_fmt)
  );

  asrx_word_align #(.WORD_W(WORD_W)) u_align (
    .clk          (clk),
    .rst          (rst),
    .word_done    (word_done),
    .word_data    (word_data),
    .word_left    (word_left),
    .word_fmt     (word_fmt),
    .left_out     (left_out),
    .right_out    (right_out),
    .sample_valid (sample_valid)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !sample_valid);

endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt = 3'b010;
  logic [23:0] left_out, right_out;
  logic        sample_valid;

  always #10 clk = ~clk;

  audio_serial_rx u_dut (
    .clk          (clk),
    .rst          (rst),
    .bclk_in      (bclk),
    .lrck_in      (lrck),
    .sdata_in     (sdata),
    .fmt_sel      (fmt),
    .left_out     (left_out),
    .right_out    (right_out),
    .sample_valid (sample_valid)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  int          strobes = 0;
  logic [23:0] cap_l = '0, cap_r = '0;
  logic        prev_v = 1'b0;
  logic        dbl = 1'b0;

  always @(negedge clk) begin
    prev_v <= sample_valid;
    if (sample_valid) begin
      strobes <= strobes + 1;
      cap_l   <= left_out;
      cap_r   <= right_out;
    end
    if (sample_valid && prev_v) dbl <= 1'b1;
  end

  typedef struct packed {
    logic [2:0]  f;
    logic [5:0]  bph;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 6'd32, 24'h123456, 24'hABCDEF},  // R2
    '{3'd2, 6'd24, 24'h800000, 24'h7FFFFF},  // R2 minimum rate
    '{3'd3, 6'd32, 24'hC0FFEE, 24'h012345},  // R3
    '{3'd3, 6'd24, 24'hA5A5A5, 24'h5A5A5B},  // R3 minimum rate
    '{3'd4, 6'd32, 24'h876543, 24'h0FEDCB},  // R4
    '{3'd4, 6'd24, 24'hFFFFFE, 24'h000001},  // R4 minimum rate
    '{3'd1, 6'd32, 24'h081234, 24'h07ABCD},  // R5
    '{3'd1, 6'd20, 24'h07FFFF, 24'h080000},  // R5 minimum rate
    '{3'd0, 6'd32, 24'h008001, 24'h007FFF},  // R6
    '{3'd0, 6'd16, 24'h00FFFF, 24'h001234},  // R6 minimum rate
    '{3'd7, 6'd32, 24'h13579B, 24'h2468AC},  // R9
    '{3'd5, 6'd24, 24'hF00F0F, 24'h0FF0F1}   // R9
  };

  function automatic logic [2:0] eff(input logic [2:0] f);
    return (f > 3'd4) ? 3'd2 : f;
  endfunction

  function automatic int nbits(input logic [2:0] f);
    case (eff(f))
      3'd0:    return 16;
      3'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic bit_of(input logic [2:0] f, input int bph,
                                  input logic [23:0] cur, input logic [23:0] prev,
                                  input int i);
    logic [2:0] e;
    int n;
    e = eff(f);
    n = nbits(f);
    if (e == 3'd3) begin
      if (i == 0) return prev[0];
      if (i <= 24) return cur[24-i];
      return 1'b1;
    end
    if (e == 3'd2) return (i < 24) ? cur[23-i] : 1'b1;
    if (i >= bph - n) return cur[bph-1-i];
    return 1'b1;
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w);
    logic [23:0] m;
    int n;
    n = nbits(f);
    m = w;
    for (int k = n; k < 24; k++) m[k] = w[n-1];
    return m;
  endfunction

  task automatic check_word(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic lvl, input logic d);
    @(negedge clk);
    bclk  = 1'b0;
    lrck  = lvl;
    sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(input logic [2:0] f, input int bph, input logic lvl,
                           input logic [23:0] cur, input logic [23:0] prev);
    for (int i = 0; i < bph; i++) bit_out(lvl, bit_of(f, bph, cur, prev, i));
  endtask

  task automatic do_reset();
    rst  = 1'b1;
    bclk = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    logic ll;
    int   base;
    do_reset();
    fmt  = v.f;
    ll   = (eff(v.f) == 3'd3) ? 1'b0 : 1'b1;
    base = strobes;
    send_half(v.f, 4, !ll, 24'h0, 24'h0);
    send_half(v.f, int'(v.bph), ll, v.l, 24'h0);
    send_half(v.f, int'(v.bph), !ll, v.r, v.l);
    bit_out(ll, bit_of(v.f, int'(v.bph), 24'h0, v.r, 0));
    bit_out(ll, 1'b1);
    repeat (12) @(negedge clk);
    check_int($sformatf("R7 strobe count fmt=%0d", v.f), strobes - base, 1);
    check_word($sformatf("R2-R6,R9 left fmt=%0d bph=%0d", v.f, v.bph),
               cap_l, expect_word(v.f, v.l));
    check_word($sformatf("R2-R6,R9 right fmt=%0d bph=%0d", v.f, v.bph),
               cap_r, expect_word(v.f, v.r));
  endtask

  initial begin
    int base;
    // R1: reset state
    repeat (3) @(negedge clk);
    check_word("R1 left in reset", left_out, 24'h0);
    check_word("R1 right in reset", right_out, 24'h0);
    check_int("R1 strobe in reset", int'(sample_valid), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check_int("R1 strobe after reset", int'(sample_valid), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R1: reset clears outputs after activity
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_word("R1 left after re-reset", left_out, 24'h0);
    check_word("R1 right after re-reset", right_out, 24'h0);
    rst = 1'b0;

    // R8: stream entered mid left half-frame
    do_reset();
    fmt  = 3'b010;
    base = strobes;
    for (int i = 0; i < 10; i++) bit_out(1'b1, 1'b1);
    send_half(3'd2, 32, 1'b0, 24'h111111, 24'h0);
    send_half(3'd2, 32, 1'b1, 24'h654321, 24'h0);
    repeat (12) @(negedge clk);
    check_int("R8 no strobe from partial frame", strobes - base, 0);
    send_half(3'd2, 32, 1'b0, 24'h0ABCDE, 24'h0);
    bit_out(1'b1, 1'b0);
    bit_out(1'b1, 1'b1);
    repeat (12) @(negedge clk);
    check_int("R8 strobe after full pair", strobes - base, 1);
    check_word("R8 left", cap_l, 24'h654321);
    check_word("R8 right", cap_r, 24'h0ABCDE);

    check_int("R7 strobe width one cycle", int'(dbl), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule